// File: doc/BRIEF.md
# Oversampled Serial Receiver with Mode-Selected FIFO Storage

This block is one receive channel of an asynchronous serial port. It watches a single RX line with a 16x oversampling tick and accepts a start bit only if the line is still low at the middle of that bit. It then samples 7, 8 or 9 data bits, least significant first, each at its centre. An optional parity bit and a stop bit follow the data. For each character it records parity errors, framing errors, line breaks and overruns.

Every character ends up in a byte-wide receive FIFO, and a storage mode selects what is written. In normal mode only the data byte is stored. A 9-bit character keeps just its low 8 bits, and all error information is lost. In status mode each character takes two FIFO entries: the low data byte, then a status byte that carries the ninth bit and the four condition flags. If a character arrives while the FIFO cannot hold all of its entries, the whole character is dropped. The overrun is then reported with the next character that is stored. A consumer drains the FIFO through a show-ahead read port.

Top module: `uart_rx_store`

## Requirements
- R1: After a synchronous active-low reset the FIFO is empty and `empty_o` is high.
- R2: A falling edge starts a character only if the line is still low at the mid-point of the start bit. A low pulse shorter than half a bit time stores nothing.
- R3: Data bits are taken least significant first, one every 16 ticks at the bit centre. `cfg_bits_i` selects the character width: 0 gives 7 bits, 1 gives 8 bits, 2 gives 9 bits, and 3 is treated as 8 bits. The width, parity enable and parity sense are captured when a start bit is first seen.
- R4: With `cfg_stat_mode_i` low, each accepted character writes exactly one FIFO entry. That entry is the low 8 data bits, with a 7-bit character zero-extended. Bit 8 and all error and break flags are discarded.
- R5: With `cfg_stat_mode_i` high, each accepted character writes two entries, data low byte first. The status byte that follows has bit 0 = data bit 8, bit 1 = parity error, bit 2 = framing error, bit 3 = overrun, bit 4 = break, and bits 7..5 zero.
- R6: When `cfg_par_en_i` is high, a parity bit follows the data. With `cfg_par_odd_i` low, the data bits plus the parity bit must hold an even number of ones; with it high, an odd number. A mismatch flags a parity error.
- R7: A stop bit sampled low flags a framing error. After such a character, a new start bit is accepted only once the line has returned high.
- R8: A break is flagged when every data bit and the stop bit are low. A break always carries a framing error too.
- R9: A character that needs more entries than the FIFO has free (1 in normal mode, 2 in status mode) is dropped entirely and sets an overrun-pending flag. The next stored character clears that flag, and in status mode it reports the flag in its status byte. A store in normal mode clears the flag without reporting it.
- R10: While `empty_o` is low, `rd_data_o` shows the oldest entry, and `rd_en_i` removes it at the clock edge. `rd_en_i` has no effect while the FIFO is empty. The order is first in, first out, and the depth is set by the parameter `DEPTH` (default 384).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_i | input | 1 | Serial receive line, idle high, asynchronous |
| tick16_i | input | 1 | One-cycle enable pulse at 16 times the bit rate |
| cfg_bits_i | input | 2 | Character width code (0: 7, 1: 8, 2: 9, 3: 8) |
| cfg_par_en_i | input | 1 | Parity bit present |
| cfg_par_odd_i | input | 1 | Odd parity when high, even when low |
| cfg_stat_mode_i | input | 1 | Status-byte storage mode when high |
| rd_en_i | input | 1 | Remove the oldest FIFO entry |
| rd_data_o | output | 8 | Oldest FIFO entry (show-ahead) |
| empty_o | output | 1 | FIFO holds no entries |

## Verification
The bench sends characters with all 0s, all 1s and alternating bit patterns at each of the three widths. This separates the LSB-first ordering and the width masking from plain stuck-at behaviour. Status mode is run with correct even and odd parity, with parity deliberately flipped, with a low stop bit on non-zero data, and with an all-zero frame. This tells a parity error apart from a framing error and from a break, and shows where the ninth bit lands. A short low glitch must leave the FIFO empty. A deliberately filled FIFO is used to show that an overrun drops a whole character and is reported exactly once, including the case where status mode has only one free entry.

// File: rtl/uart_rx_pkg.sv
// Package: shared types and helpers for the oversampled receive channel.
// Assumes: consumers import it before use; no state lives here.
package uart_rx_pkg;

    // Receiver frame sequencer states.
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_WAIT
    } rx_state_t;

    // One received character with its condition flags.
    typedef struct packed {
        logic [8:0] data;
        logic       perr;
        logic       ferr;
        logic       brk;
    } rx_frame_t;

    // Status byte bit positions.
    localparam int unsigned ST_BIT8 = 0;
    localparam int unsigned ST_PERR = 1;
    localparam int unsigned ST_FERR = 2;
    localparam int unsigned ST_OVR  = 3;
    localparam int unsigned ST_BRK  = 4;

    // Map the width code onto a data bit count.
    function automatic logic [3:0] width_of(input logic [1:0] code);
        case (code)
            2'd0:    width_of = 4'd7;
            2'd2:    width_of = 4'd9;
            default: width_of = 4'd8;
        endcase
    endfunction

    // Assemble the status byte stored after a data byte.
    function automatic logic [7:0] status_of(input rx_frame_t f, input logic ovr);
        logic [7:0] s;
        s          = 8'h00;
        s[ST_BIT8] = f.data[8];
        s[ST_PERR] = f.perr;
        s[ST_FERR] = f.ferr;
        s[ST_OVR]  = ovr;
        s[ST_BRK]  = f.brk;
        return s;
    endfunction

endpackage

// File: rtl/rx_frame_sampler.sv
// Module: rx_frame_sampler
// Synchronises the RX line, validates the start bit at mid-bit, samples
// data, parity and stop bits at their centres on the oversampling tick and
// emits one single-cycle frame pulse carrying data and condition flags.
// Assumes: tick_i is a one-cycle pulse at OVS times the bit rate; the
// configuration is stable around a start edge.
module rx_frame_sampler
    import uart_rx_pkg::*;
#(
    parameter int unsigned OVS         = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_i,
    input  logic       tick_i,
    input  logic [1:0] cfg_bits_i,
    input  logic       cfg_par_en_i,
    input  logic       cfg_par_odd_i,
    output logic       frame_valid_o,
    output rx_frame_t  frame_o
);

    localparam int unsigned CW = $clog2(OVS);
    localparam logic [CW-1:0] MID_C  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST_C = CW'(OVS - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rx_s;
    rx_state_t              state;
    logic [CW-1:0]          cnt;
    logic [3:0]             bit_idx;
    logic [3:0]             nb_q;
    logic                   par_en_q;
    logic                   par_odd_q;
    logic                   pbit_q;
    logic [8:0]             shreg;
    logic [8:0]             data_al;

    // Purpose: bring the asynchronous line into the clock domain, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
    end

    assign rx_s = sync_q[SYNC_STAGES-1];

    // Purpose: right-align the shifted data to the captured width.
    always_comb begin
        case (nb_q)
            4'd7:    data_al = {2'b00, shreg[8:2]};
            4'd8:    data_al = {1'b0, shreg[8:1]};
            default: data_al = shreg;
        endcase
    end

    // Purpose: frame sequencer, bit-centre sampling and frame result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= RX_IDLE;
            cnt           <= '0;
            bit_idx       <= '0;
            nb_q          <= 4'd8;
            par_en_q      <= 1'b0;
            par_odd_q     <= 1'b0;
            pbit_q        <= 1'b0;
            shreg         <= '0;
            frame_valid_o <= 1'b0;
            frame_o       <= '0;
        end else begin
            frame_valid_o <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (!rx_s) begin
                        state     <= RX_START;
                        cnt       <= '0;
                        nb_q      <= width_of(cfg_bits_i);
                        par_en_q  <= cfg_par_en_i;
                        par_odd_q <= cfg_par_odd_i;
                    end
                end
                RX_START: begin
                    if (tick_i) begin
                        if (cnt == MID_C) begin
                            cnt     <= '0;
                            bit_idx <= '0;
                            shreg   <= '0;
                            state   <= rx_s ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (tick_i) begin
                        if (cnt == LAST_C) begin
                            cnt     <= '0;
                            shreg   <= {rx_s, shreg[8:1]};
                            bit_idx <= bit_idx + 4'd1;
                            if (bit_idx == nb_q - 4'd1)
                                state <= par_en_q ? RX_PAR : RX_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                RX_PAR: begin
                    if (tick_i) begin
                        if (cnt == LAST_C) begin
                            cnt    <= '0;
                            pbit_q <= rx_s;
                            state  <= RX_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                RX_STOP: begin
                    if (tick_i) begin
                        if (cnt == LAST_C) begin
                            cnt           <= '0;
                            frame_valid_o <= 1'b1;
                            frame_o.data  <= data_al;
                            frame_o.perr  <= par_en_q & (^data_al ^ pbit_q ^ par_odd_q);
                            frame_o.ferr  <= ~rx_s;
                            frame_o.brk   <= ~rx_s & (data_al == 9'd0);
                            state         <= rx_s ? RX_IDLE : RX_WAIT;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                RX_WAIT: begin
                    if (rx_s) state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // R3: a frame result is a single-cycle event.
    assert_single_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid_o |=> !frame_valid_o);

    // R8: a break always carries a framing error.
    assert_break_ferr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid_o && frame_o.brk) |-> frame_o.ferr);

    // R7: after a low stop bit the sequencer waits for the line to go high.
    assert_wait_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid_o && frame_o.ferr) |-> (state == RX_WAIT));

endmodule

// File: rtl/rx_store_ctrl.sv
// Module: rx_store_ctrl
// Decides what a finished frame writes into the FIFO: one data byte in
// normal mode, or a data byte followed by a status byte in status mode.
// Drops a frame that does not fit and carries an overrun flag to the next
// stored frame.
// Assumes: frames arrive many cycles apart, so the status write slot is free.
module rx_store_ctrl
    import uart_rx_pkg::*;
#(
    parameter int unsigned DEPTH = 384,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_valid_i,
    input  rx_frame_t     frame_i,
    input  logic          stat_mode_i,
    input  logic [CW-1:0] free_i,
    output logic          wr_en_o,
    output logic [7:0]    wr_data_o
);

    logic          stat_pend_q;
    logic [7:0]    stat_byte_q;
    logic          ovr_pend_q;
    logic [CW-1:0] need_w;

    assign need_w = stat_mode_i ? CW'(2) : CW'(1);

    // Purpose: issue data and status writes and keep the overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en_o     <= 1'b0;
            wr_data_o   <= '0;
            stat_pend_q <= 1'b0;
            stat_byte_q <= '0;
            ovr_pend_q  <= 1'b0;
        end else begin
            wr_en_o <= 1'b0;
            if (stat_pend_q) begin
                wr_en_o     <= 1'b1;
                wr_data_o   <= stat_byte_q;
                stat_pend_q <= 1'b0;
            end else if (frame_valid_i) begin
                if (free_i >= need_w) begin
                    wr_en_o    <= 1'b1;
                    wr_data_o  <= frame_i.data[7:0];
                    ovr_pend_q <= 1'b0;
                    if (stat_mode_i) begin
                        stat_pend_q <= 1'b1;
                        stat_byte_q <= status_of(frame_i, ovr_pend_q);
                    end
                end else begin
                    ovr_pend_q <= 1'b1;
                end
            end
        end
    end

    // R4: a normal-mode frame produces at most one write.
    assert_one_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid_i && !stat_mode_i) |=> ##1 !wr_en_o);

    // R5: a status-mode frame that fits produces two back-to-back writes.
    assert_two_entries_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid_i && stat_mode_i && free_i >= CW'(2)) |=> (wr_en_o ##1 wr_en_o));

    // R9: a frame that does not fit writes nothing.
    assert_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid_i && !stat_pend_q && free_i < need_w) |=> !wr_en_o);

endmodule

// File: rtl/rx_byte_fifo.sv
// Module: rx_byte_fifo
// Show-ahead byte FIFO of any depth (not limited to powers of two), with
// wrapping pointers and an occupancy count that yields the free space.
// Assumes: the writer never writes when full; reads while empty are ignored.
module rx_byte_fifo #(
    parameter int unsigned DEPTH = 384,
    parameter int unsigned W     = 8,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [W-1:0]  wr_data_i,
    input  logic          rd_en_i,
    output logic [W-1:0]  rd_data_o,
    output logic          empty_o,
    output logic [CW-1:0] free_o
);

    localparam int unsigned PW = $clog2(DEPTH);
    localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] count;
    logic          do_wr;
    logic          do_rd;

    assign do_wr     = wr_en_i && (count != CNT_FULL);
    assign do_rd     = rd_en_i && (count != '0);
    assign empty_o   = (count == '0);
    assign free_o    = CNT_FULL - count;
    assign rd_data_o = mem[rd_ptr];

    // Purpose: storage array write port (contents need no reset).
    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data_i;
    end

    // Purpose: pointer wrap and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R9: the store controller never writes into a full FIFO.
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> (count != CNT_FULL));

    // R10: a read of an empty FIFO leaves it empty.
    assert_empty_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && empty_o && !wr_en_i) |=> empty_o);

    // R10: occupancy stays within the depth.
    assert_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_FULL);

endmodule

// File: rtl/uart_rx_store.sv
// Module: uart_rx_store
// Top of the receive channel: frame sampler, store controller and byte FIFO.
// Assumes: tick16_i pulses at 16x the bit rate; DEPTH >= 2.
module uart_rx_store
    import uart_rx_pkg::*;
#(
    parameter int unsigned DEPTH       = 384,
    parameter int unsigned OVS         = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_i,
    input  logic       tick16_i,
    input  logic [1:0] cfg_bits_i,
    input  logic       cfg_par_en_i,
    input  logic       cfg_par_odd_i,
    input  logic       cfg_stat_mode_i,
    input  logic       rd_en_i,
    output logic [7:0] rd_data_o,
    output logic       empty_o
);

    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic          frame_valid;
    rx_frame_t     frame;
    logic          wr_en;
    logic [7:0]    wr_data;
    logic [CW-1:0] free;

    rx_frame_sampler #(
        .OVS         (OVS),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sampler (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_i          (rx_i),
        .tick_i        (tick16_i),
        .cfg_bits_i    (cfg_bits_i),
        .cfg_par_en_i  (cfg_par_en_i),
        .cfg_par_odd_i (cfg_par_odd_i),
        .frame_valid_o (frame_valid),
        .frame_o       (frame)
    );

    rx_store_ctrl #(
        .DEPTH (DEPTH),
        .CW    (CW)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_valid_i (frame_valid),
        .frame_i       (frame),
        .stat_mode_i   (cfg_stat_mode_i),
        .free_i        (free),
        .wr_en_o       (wr_en),
        .wr_data_o     (wr_data)
    );

    rx_byte_fifo #(
        .DEPTH (DEPTH),
        .W     (8),
        .CW    (CW)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .rd_en_i   (rd_en_i),
        .rd_data_o (rd_data_o),
        .empty_o   (empty_o),
        .free_o    (free)
    );

endmodule

// File: tb/uart_rx_store_test.sv
`timescale 1ns/1ps
module uart_rx_store_test;

    localparam int DEPTH = 8;
    localparam int BITCYC = 32; // 16 ticks, one tick every 2 cycles

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] cfg_bits = 2'd1;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_stat = 1'b0;
    logic       rd_en = 1'b0;
    logic       man_rd = 1'b0;
    logic [7:0] rd_data;
    logic       empty;

    int total = 0;
    int bad = 0;
    bit drain_en = 1'b0;
    bit m_ovr = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    uart_rx_store #(.DEPTH(DEPTH)) uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .rx_i            (rx),
        .tick16_i        (tick),
        .cfg_bits_i      (cfg_bits),
        .cfg_par_en_i    (cfg_par_en),
        .cfg_par_odd_i   (cfg_par_odd),
        .cfg_stat_mode_i (cfg_stat),
        .rd_en_i         (rd_en | man_rd),
        .rd_data_o       (rd_data),
        .empty_o         (empty)
    );

    // oversampling tick every other cycle
    always @(negedge clk) tick <= rst_n ? ~tick : 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pop scoreboard and compare each FIFO entry as it appears
    always @(negedge clk) begin
        if (!rst_n) rd_en <= 1'b0;
        else if (rd_en) rd_en <= 1'b0;
        else if (drain_en && !empty) begin
            if (exp_q.size() == 0) chk(1'b0, "R10 unexpected entry", rd_data, 0);
            else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rd_data == e, t, rd_data, e);
            end
            rd_en <= 1'b1;
        end
    end

    task automatic hold(input logic v, input int cyc);
        rx = v;
        repeat (cyc) @(negedge clk);
    endtask

    // driver: predict FIFO entries from the requirements, then send the frame
    task automatic xmit(input logic [8:0] d, input logic flip_par, input logic stop, input string tag);
        int nb;
        logic [8:0] dm;
        logic pbit, perr, ferr, brk;
        int need, room;
        nb = (cfg_bits == 2'd0) ? 7 : (cfg_bits == 2'd2) ? 9 : 8;
        dm = (nb == 7) ? (d & 9'h07F) : (nb == 8) ? (d & 9'h0FF) : d;
        pbit = (^dm) ^ cfg_par_odd ^ flip_par;
        perr = cfg_par_en & flip_par;
        ferr = ~stop;
        brk  = ~stop & (dm == 9'd0);
        need = cfg_stat ? 2 : 1;
        room = drain_en ? DEPTH : DEPTH - exp_q.size();
        if (room < need) m_ovr = 1'b1;
        else begin
            exp_q.push_back(dm[7:0]);
            tag_q.push_back({tag, " data"});
            if (cfg_stat) begin
                exp_q.push_back({3'b000, brk, m_ovr, ferr, perr, dm[8]});
                tag_q.push_back({tag, " status"});
            end
            m_ovr = 1'b0;
        end
        hold(1'b0, BITCYC);
        for (int i = 0; i < nb; i++) hold(dm[i], BITCYC);
        if (cfg_par_en) hold(pbit, BITCYC);
        hold(stop, BITCYC);
        hold(1'b1, BITCYC / 2);
    endtask

    task automatic drain_all();
        drain_en = 1'b1;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [1:0] b, input logic pe, input logic po, input logic st);
        cfg_bits = b; cfg_par_en = pe; cfg_par_odd = po; cfg_stat = st;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(empty == 1'b1, "R1 empty after reset", empty, 1);

        // R10: read of empty FIFO ignored; then show-ahead data
        man_rd = 1'b1; @(negedge clk); man_rd = 1'b0;
        set_cfg(2'd1, 1'b0, 1'b0, 1'b0);
        xmit(9'h05A, 1'b0, 1'b1, "R10 peek");
        repeat (4) @(negedge clk);
        chk(empty == 1'b0, "R10 not empty", empty, 0);
        chk(rd_data == 8'h5A, "R10 show-ahead", rd_data, 8'h5A);
        drain_all();

        // R3 R4: normal mode, 8 bits, several patterns
        xmit(9'h0A5, 1'b0, 1'b1, "R3 8b A5");
        xmit(9'h000, 1'b0, 1'b1, "R4 8b 00");
        xmit(9'h0FF, 1'b0, 1'b1, "R4 8b FF");
        xmit(9'h1C3, 1'b0, 1'b1, "R3 8b C3");
        // R3: 7-bit
        set_cfg(2'd0, 1'b0, 1'b0, 1'b0);
        xmit(9'h055, 1'b0, 1'b1, "R3 7b 55");
        xmit(9'h07F, 1'b0, 1'b1, "R3 7b 7F");
        // R4: 9-bit truncated, parity error discarded
        set_cfg(2'd2, 1'b0, 1'b0, 1'b0);
        xmit(9'h1A5, 1'b0, 1'b1, "R4 9b 1A5");
        set_cfg(2'd3, 1'b1, 1'b0, 1'b0);
        xmit(9'h0E1, 1'b1, 1'b1, "R4 perr discarded");
        // R4 R7: framing error in normal mode stores data only
        set_cfg(2'd1, 1'b0, 1'b0, 1'b0);
        xmit(9'h03C, 1'b0, 1'b0, "R7 normal ferr");
        drain_all();

        // R5 R6: status mode with parity
        set_cfg(2'd1, 1'b1, 1'b0, 1'b1);
        xmit(9'h0B7, 1'b0, 1'b1, "R6 even ok");
        xmit(9'h0B7, 1'b1, 1'b1, "R6 even bad");
        set_cfg(2'd1, 1'b1, 1'b1, 1'b1);
        xmit(9'h034, 1'b0, 1'b1, "R6 odd ok");
        xmit(9'h034, 1'b1, 1'b1, "R6 odd bad");
        set_cfg(2'd0, 1'b1, 1'b1, 1'b1);
        xmit(9'h045, 1'b0, 1'b1, "R6 7b odd ok");
        set_cfg(2'd2, 1'b0, 1'b0, 1'b1);
        xmit(9'h155, 1'b0, 1'b1, "R5 9b bit8");
        xmit(9'h0AA, 1'b0, 1'b1, "R5 9b bit8 low");
        // R7 R8: framing and break
        set_cfg(2'd1, 1'b0, 1'b0, 1'b1);
        xmit(9'h081, 1'b0, 1'b0, "R7 ferr");
        xmit(9'h000, 1'b0, 1'b0, "R8 break");
        xmit(9'h066, 1'b0, 1'b1, "R7 after wait");
        drain_all();

        // R2: glitch shorter than half a bit stores nothing
        drain_en = 1'b0;
        hold(1'b0, 8);
        hold(1'b1, 4 * BITCYC);
        chk(empty == 1'b1, "R2 glitch rejected", empty, 1);
        xmit(9'h0C9, 1'b0, 1'b1, "R2 real start");
        drain_all();

        // R9: status mode with only one free entry drops the character
        drain_en = 1'b0;
        set_cfg(2'd1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < DEPTH - 1; i++) xmit(9'h010 + 9'(i), 1'b0, 1'b1, "R9 fill");
        cfg_stat = 1'b1;
        xmit(9'h0EE, 1'b0, 1'b1, "R9 dropped");
        chk(exp_q.size() == DEPTH - 1, "R9 model level", exp_q.size(), DEPTH - 1);
        drain_all();
        xmit(9'h02A, 1'b0, 1'b1, "R9 ovr reported");
        xmit(9'h02B, 1'b0, 1'b1, "R9 ovr cleared");
        drain_all();

        // R9: normal-mode overrun cleared by next normal store
        drain_en = 1'b0;
        cfg_stat = 1'b0;
        for (int i = 0; i < DEPTH; i++) xmit(9'h040 + 9'(i), 1'b0, 1'b1, "R9 fill2");
        xmit(9'h0DD, 1'b0, 1'b1, "R9 dropped2");
        drain_all();
        xmit(9'h071, 1'b0, 1'b1, "R9 normal store");
        cfg_stat = 1'b1;
        xmit(9'h072, 1'b0, 1'b1, "R9 no stale ovr");
        drain_all();

        chk(exp_q.size() == 0, "R10 all entries seen", exp_q.size(), 0);
        chk(empty == 1'b1, "R10 empty at end", empty, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule